// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a synchronous front end for a parallel NOR-style flash device. It takes bus write cycles, each an address with a 16-bit data word, and decodes them into commands. It tracks two-cycle and multi-cycle sequences: single-word program, buffered program, streaming program and block erase. It keeps a status byte with sticky error flags and decides what the 16-bit read port returns. The read port can show the array, the status byte, identifier codes or query codes.

Program and erase run on an internal engine. A cycle counter stands in for the engine's busy time, and the engine can be suspended and resumed. The array is a small stub of `2**AW` words that holds a single erase block. Programming can only clear bits, so a programmed word becomes its old value ANDed with the new data. Commands are decoded from data bits [7:0].

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, reads are in array mode, every stub word reads 0xFFFF, `busy` is 0, and the status byte reads 0x80.
- R2: In the idle state, 0xFF selects array reads and 0x70 selects status reads, returned as {8'h00, status}. 0x90 selects identifier reads: address 0 gives MFR_ID, address 1 gives DEV_ID, and every other address gives 0. 0x98 selects query reads: addresses 0, 1 and 2 give 0x0051, 0x0052 and 0x0059, and every other address gives 0.
- R3: Status layout: bit 7 is ready (0 only while the engine runs), bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 2 is program suspended, and all other bits are 0. Error bits stay set until 0x50 is written in the idle state, which clears bits 5 and 4.
- R4: 0x40 followed by a write (address A, data D) holds `busy` high for PROG_CYC cycles. After that, word A reads old & D.
- R5: 0x20 followed by 0xD0 holds `busy` high for ERASE_CYC cycles. After that, every stub word reads 0xFFFF.
- R6: If 0x20, 0x80 or a filled program buffer is followed by any code other than 0xD0, status bits 5 and 4 are both set and the sequencer returns to idle. The array is left unchanged and the engine does not start.
- R7: A buffered program is 0xE8, then a count N-1, then N writes of (address, data), then 0xD0. This holds `busy` high for PROG_CYC cycles and then ANDs each loaded word into its address. A count above 255 sets status bits 5 and 4 and returns to idle without loading any words.
- R8: While the engine runs, only 0x70 and 0xB0 are honoured. Any other write leaves the read mode and the remaining busy time unchanged.
- R9: 0xB0 during a run freezes the remaining time, drops `busy`, and sets status bit 6 (erase) or bit 2 (program). While suspended, 0xFF, 0x70, 0x90 and 0x98 change the read mode. 0xD0 resumes the run in status mode, and the total busy time equals the unsuspended time.
- R10: 0x80 then 0xD0 at address B enters streaming mode. Each later write ANDs its data into word B, B+1, and so on (wrapping within the stub) with no command decoding. A data word of 0xFFFF leaves the mode. Reads in this mode return status.
- R11: Any program or erase setup code (0x40, 0xE8, 0x20, 0x80) switches reads to status mode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data; commands are taken from bits [7:0] |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read data for the current read mode (combinational) |
| busy | output | 1 | Engine running and not suspended |

## Verification
A sequencer stuck in the wrong state shows up at the read port on the next read. A command that should be decoded gets absorbed as data, or a confirm is missed, and the status byte differs from the expected value straight away. A wrong busy counter shows up as a busy pulse whose length differs from the programmed cycle count, which is measured to the cycle, including across a suspend. A wrong array update stays hidden until the next array-mode sweep, which follows every operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PGM_ARM, ST_BUF_CNT, ST_BUF_LOAD, ST_BUF_CONF,
        ST_ERS_ARM, ST_STRM_ARM, ST_STRM, ST_BUSY, ST_SUSP
    } seq_state_e;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rd_mode_e;

    typedef enum logic [1:0] {OP_WORD, OP_BUF, OP_ERASE} eng_op_e;

    localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] C_RD_STATUS = 8'h70;
    localparam logic [7:0] C_RD_IDENT  = 8'h90;
    localparam logic [7:0] C_RD_QUERY  = 8'h98;
    localparam logic [7:0] C_CLR_ERR   = 8'h50;
    localparam logic [7:0] C_PGM       = 8'h40;
    localparam logic [7:0] C_BUF_PGM   = 8'hE8;
    localparam logic [7:0] C_STRM      = 8'h80;
    localparam logic [7:0] C_ERASE     = 8'h20;
    localparam logic [7:0] C_CONFIRM   = 8'hD0;
    localparam logic [7:0] C_SUSPEND   = 8'hB0;

endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    input  logic          freeze,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = load;
        else if (cnt_q != '0 && !freeze)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = !start && !freeze && (cnt_q == CW'(1));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !start) |=> $stable(cnt_q));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/fcs_rdmux.sv
module fcs_rdmux import flash_cmd_pkg::*; #(
    parameter int          AW     = 4,
    parameter logic [15:0] MFR_ID = 16'h0031,
    parameter logic [15:0] DEV_ID = 16'h7E21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rd_mode_e      mode,
    input  logic [7:0]    sr,
    input  logic [15:0]   arr_word,
    input  logic [AW-1:0] addr,
    output logic [15:0]   rd_data
);
    always_comb begin
        rd_data = '0;
        unique case (mode)
            RM_ARRAY:  rd_data = arr_word;
            RM_STATUS: rd_data = {8'h00, sr};
            RM_IDENT: begin
                if (addr == AW'(0))      rd_data = MFR_ID;
                else if (addr == AW'(1)) rd_data = DEV_ID;
            end
            RM_QUERY: begin
                if (addr == AW'(0))      rd_data = 16'h0051;
                else if (addr == AW'(1)) rd_data = 16'h0052;
                else if (addr == AW'(2)) rd_data = 16'h0059;
            end
            default: rd_data = '0;
        endcase
    end

    // R2
    status_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_STATUS || mode == RM_QUERY) |-> (rd_data[15:8] == 8'h00));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import flash_cmd_pkg::*; #(
    parameter int          AW        = 4,
    parameter int          PROG_CYC  = 16,
    parameter int          ERASE_CYC = 64,
    parameter logic [15:0] MFR_ID    = 16'h0031,
    parameter logic [15:0] DEV_ID    = 16'h7E21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    output logic          busy
);
    localparam int WORDS   = 1 << AW;
    localparam int CYC_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(CYC_MAX + 1);

    typedef struct packed {
        seq_state_e                st;
        rd_mode_e                  mode;
        eng_op_e                   op;
        logic                      susp_ers;
        logic                      susp_pgm;
        logic                      err_ers;
        logic                      err_pgm;
        logic [AW-1:0]             tgt_addr;
        logic [15:0]               tgt_data;
        logic [7:0]                left;
        logic [AW-1:0]             ptr;
        logic [WORDS-1:0]          pend;
        logic [WORDS-1:0][15:0]    pdata;
        logic [WORDS-1:0][15:0]    mem;
    } seq_t;

    seq_t          s_d, s_q;
    logic          tmr_start, tmr_busy, tmr_done, tmr_freeze;
    logic [CW-1:0] tmr_load;
    logic [7:0]    cmd, sr;

    assign cmd        = wr_data[7:0];
    assign tmr_freeze = (s_q.st == ST_SUSP);

    always_comb begin
        s_d       = s_q;
        tmr_start = 1'b0;
        tmr_load  = '0;
        if (tmr_done && s_q.st == ST_BUSY) begin
            s_d.st = ST_IDLE;
            unique case (s_q.op)
                OP_WORD:  s_d.mem[s_q.tgt_addr] = s_q.mem[s_q.tgt_addr] & s_q.tgt_data;
                OP_BUF: begin
                    for (int i = 0; i < WORDS; i++)
                        if (s_q.pend[i]) s_d.mem[i] = s_q.mem[i] & s_q.pdata[i];
                    s_d.pend = '0;
                end
                default:  s_d.mem = '1;
            endcase
        end else if (wr_en) begin
            unique case (s_q.st)
                ST_IDLE: begin
                    unique case (cmd)
                        C_RD_ARRAY:  s_d.mode = RM_ARRAY;
                        C_RD_STATUS: s_d.mode = RM_STATUS;
                        C_RD_IDENT:  s_d.mode = RM_IDENT;
                        C_RD_QUERY:  s_d.mode = RM_QUERY;
                        C_CLR_ERR: begin
                            s_d.err_ers = 1'b0;
                            s_d.err_pgm = 1'b0;
                        end
                        C_PGM:     begin s_d.st = ST_PGM_ARM;  s_d.mode = RM_STATUS; end
                        C_BUF_PGM: begin s_d.st = ST_BUF_CNT;  s_d.mode = RM_STATUS; s_d.pend = '0; end
                        C_ERASE:   begin s_d.st = ST_ERS_ARM;  s_d.mode = RM_STATUS; end
                        C_STRM:    begin s_d.st = ST_STRM_ARM; s_d.mode = RM_STATUS; end
                        default: ;
                    endcase
                end
                ST_PGM_ARM: begin
                    s_d.tgt_addr = wr_addr;
                    s_d.tgt_data = wr_data;
                    s_d.op       = OP_WORD;
                    s_d.st       = ST_BUSY;
                    tmr_start    = 1'b1;
                    tmr_load     = CW'(PROG_CYC);
                end
                ST_BUF_CNT: begin
                    if (wr_data > 16'd255) begin
                        s_d.err_ers = 1'b1;
                        s_d.err_pgm = 1'b1;
                        s_d.st      = ST_IDLE;
                    end else begin
                        s_d.left = wr_data[7:0];
                        s_d.st   = ST_BUF_LOAD;
                    end
                end
                ST_BUF_LOAD: begin
                    s_d.pend[wr_addr]  = 1'b1;
                    s_d.pdata[wr_addr] = wr_data;
                    if (s_q.left == 8'd0) s_d.st = ST_BUF_CONF;
                    else                  s_d.left = s_q.left - 8'd1;
                end
                ST_BUF_CONF, ST_ERS_ARM, ST_STRM_ARM: begin
                    if (cmd != C_CONFIRM) begin
                        s_d.err_ers = 1'b1;
                        s_d.err_pgm = 1'b1;
                        s_d.pend    = '0;
                        s_d.st      = ST_IDLE;
                    end else if (s_q.st == ST_STRM_ARM) begin
                        s_d.ptr = wr_addr;
                        s_d.st  = ST_STRM;
                    end else begin
                        s_d.op    = (s_q.st == ST_ERS_ARM) ? OP_ERASE : OP_BUF;
                        s_d.st    = ST_BUSY;
                        tmr_start = 1'b1;
                        tmr_load  = (s_q.st == ST_ERS_ARM) ? CW'(ERASE_CYC) : CW'(PROG_CYC);
                    end
                end
                ST_STRM: begin
                    if (wr_data == 16'hFFFF) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.mem[s_q.ptr] = s_q.mem[s_q.ptr] & wr_data;
                        s_d.ptr          = s_q.ptr + 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (cmd == C_RD_STATUS) s_d.mode = RM_STATUS;
                    else if (cmd == C_SUSPEND) begin
                        s_d.st = ST_SUSP;
                        if (s_q.op == OP_ERASE) s_d.susp_ers = 1'b1;
                        else                    s_d.susp_pgm = 1'b1;
                    end
                end
                ST_SUSP: begin
                    unique case (cmd)
                        C_RD_ARRAY:  s_d.mode = RM_ARRAY;
                        C_RD_STATUS: s_d.mode = RM_STATUS;
                        C_RD_IDENT:  s_d.mode = RM_IDENT;
                        C_RD_QUERY:  s_d.mode = RM_QUERY;
                        C_CONFIRM: begin
                            s_d.st       = ST_BUSY;
                            s_d.mode     = RM_STATUS;
                            s_d.susp_ers = 1'b0;
                            s_d.susp_pgm = 1'b0;
                        end
                        default: ;
                    endcase
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.mem <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    fcs_timer #(.CW(CW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .load   (tmr_load),
        .freeze (tmr_freeze),
        .busy   (tmr_busy),
        .done   (tmr_done)
    );

    assign sr   = {s_q.st != ST_BUSY, s_q.susp_ers, s_q.err_ers, s_q.err_pgm,
                   1'b0, s_q.susp_pgm, 2'b00};
    assign busy = tmr_busy && (s_q.st != ST_SUSP);

    fcs_rdmux #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (s_q.mode),
        .sr       (sr),
        .arr_word (s_q.mem[rd_addr]),
        .addr     (rd_addr),
        .rd_data  (rd_data)
    );

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err_pgm && !(wr_en && s_q.st == ST_IDLE && cmd == C_CLR_ERR)) |=> s_q.err_pgm);

    // R6
    bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.st == ST_ERS_ARM && cmd != C_CONFIRM)
        |=> (s_q.err_ers && s_q.err_pgm && s_q.st == ST_IDLE && !busy));

    // R8
    engine_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_BUSY && s_q.st != ST_SUSP) |-> !tmr_busy);

    // R9
    susp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.susp_ers && s_q.susp_pgm));

endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int PC = 5;
    localparam int EC = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] mdl [N];

    always #2 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .PROG_CYC(PC), .ERASE_CYC(EC),
                    .MFR_ID(16'h0031), .DEV_ID(16'h7E21)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(input int a, input logic [15:0] d);
        wr_addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        rd_addr = AW'(a);
        #0.001;
        v = rd_data;
    endtask

    task automatic run_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic sweep(input string tag);
        logic [15:0] v;
        wr(0, 16'h00FF);
        for (int a = 0; a < N; a++) begin rd(a, v); chk(tag, v, mdl[a]); end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        for (int a = 0; a < N; a++) mdl[a] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {15'd0, busy}, 16'h0000);
        for (int a = 0; a < N; a++) begin rd(a, v); chk("R1 array", v, 16'hFFFF); end
        wr(0, 16'h0070); rd(0, v); chk("R1 status", v, 16'h0080);

        // R2 identifier and query modes
        wr(0, 16'h0090);
        for (int a = 0; a < N; a++) begin
            rd(a, v);
            chk("R2 ident", v, a == 0 ? 16'h0031 : a == 1 ? 16'h7E21 : 16'h0000);
        end
        wr(0, 16'h0098);
        for (int a = 0; a < N; a++) begin
            rd(a, v);
            chk("R2 query", v, a == 0 ? 16'h0051 : a == 1 ? 16'h0052 : a == 2 ? 16'h0059 : 16'h0000);
        end

        // R4 word program on every address, R11 setup switches to status
        for (int a = 0; a < N; a++) begin
            logic [15:0] d;
            d = ~(16'(a) * 16'h0111) | 16'h8000;
            wr(0, 16'h00FF);
            wr(0, 16'h0040); rd(0, v); chk("R11 setup status", v, 16'h0080);
            wr(a, d);        rd(0, v); chk("R3 busy status", v, 16'h0000);
            run_busy(n);     chk("R4 busy length", 16'(n), 16'(PC));
            mdl[a] = mdl[a] & d;
        end
        sweep("R4 array");
        // second program on same word ANDs
        wr(0, 16'h0040); wr(3, 16'h0F0F); run_busy(n);
        mdl[3] = mdl[3] & 16'h0F0F;
        sweep("R4 and");

        // R8 commands ignored while busy
        wr(0, 16'h0040); wr(7, 16'h1234);
        wr(0, 16'h00FF); rd(7, v); chk("R8 ignore FF", v, 16'h0000);
        wr(0, 16'h0050);
        run_busy(n); chk("R8 time kept", 16'(n + 2), 16'(PC));
        mdl[7] = mdl[7] & 16'h1234;
        sweep("R8 array");

        // R5 erase
        wr(0, 16'h0020); rd(0, v); chk("R11 erase status", v, 16'h0080);
        wr(0, 16'h00D0); run_busy(n); chk("R5 busy length", 16'(n), 16'(EC));
        for (int a = 0; a < N; a++) mdl[a] = 16'hFFFF;
        sweep("R5 array");

        // R6 bad confirms, R3 sticky and clear
        wr(0, 16'h0020); wr(0, 16'h0033);
        rd(0, v); chk("R6 erase bad", v, 16'h00B0);
        chk("R6 no start", {15'd0, busy}, 16'h0000);
        wr(0, 16'h0040); wr(1, 16'h0000); run_busy(n);
        mdl[1] = 16'h0000;
        rd(0, v); chk("R3 sticky", v, 16'h00B0);
        wr(0, 16'h0050); rd(0, v); chk("R3 clear", v, 16'h0080);
        wr(0, 16'h0080); wr(0, 16'h0012); rd(0, v); chk("R6 stream bad", v, 16'h00B0);
        wr(0, 16'h0050);
        wr(0, 16'h00E8); wr(0, 16'h0001); wr(4, 16'h0000); wr(5, 16'h0000);
        wr(0, 16'h0044); rd(0, v); chk("R6 buffer bad", v, 16'h00B0);
        chk("R6 no busy", {15'd0, busy}, 16'h0000);
        sweep("R6 array kept");
        wr(0, 16'h0050);

        // R7 buffered program and overlong count
        wr(0, 16'h00E8); wr(0, 16'd300); rd(0, v); chk("R7 count error", v, 16'h00B0);
        wr(0, 16'h0050); rd(0, v); chk("R7 back idle", v, 16'h0080);
        wr(0, 16'h00E8); wr(0, 16'd3);
        for (int k = 0; k < 4; k++) wr(8 + k, 16'hF00F ^ 16'(k << 4));
        wr(0, 16'h00D0); run_busy(n); chk("R7 busy length", 16'(n), 16'(PC));
        for (int k = 0; k < 4; k++) mdl[8 + k] = mdl[8 + k] & (16'hF00F ^ 16'(k << 4));
        sweep("R7 array");

        // R9 program suspend and resume
        wr(0, 16'h0040); wr(6, 16'hA5A5);
        chk("R9 running", {15'd0, busy}, 16'h0001);
        wr(0, 16'h00B0); rd(0, v); chk("R9 pgm susp sr", v, 16'h0084);
        chk("R9 busy low", {15'd0, busy}, 16'h0000);
        wr(0, 16'h00FF); rd(6, v); chk("R9 array old", v, mdl[6]);
        repeat (4) @(negedge clk);
        wr(0, 16'h00D0); run_busy(n); chk("R9 pgm total", 16'(n + 1), 16'(PC));
        mdl[6] = mdl[6] & 16'hA5A5;
        sweep("R9 pgm array");
        // erase suspend
        wr(0, 16'h0020); wr(0, 16'h00D0);
        wr(0, 16'h00B0); rd(0, v); chk("R9 ers susp sr", v, 16'h00C0);
        repeat (3) @(negedge clk);
        wr(0, 16'h00D0); run_busy(n); chk("R9 ers total", 16'(n + 1), 16'(EC));
        for (int a = 0; a < N; a++) mdl[a] = 16'hFFFF;
        sweep("R9 ers array");

        // R10 streaming mode
        wr(0, 16'h0080); wr(14, 16'h00D0);
        rd(0, v); chk("R10 status", v, 16'h0080);
        wr(0, 16'h1234); wr(0, 16'h0F0F);
        wr(0, 16'h0070); rd(0, v); chk("R10 no decode", v, 16'h0080);
        wr(0, 16'hFFFF);
        chk("R10 no busy", {15'd0, busy}, 16'h0000);
        mdl[14] = 16'h1234; mdl[15] = 16'h0F0F; mdl[0] = 16'h0070;
        sweep("R10 array");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule